// File: doc/BRIEF.md
# Video RAM Block-Transfer DMA Controller

This controller copies data from anywhere in a 16-bit system address space into the video RAM window at 0x8000–0x9FFF. It always moves whole 16-byte blocks. Software loads a source and a destination address through four byte registers. It then writes a control byte that sets the block count and picks one of two modes. General mode copies every block at once. Blanking mode copies one block each time the display signals a horizontal-blank interval.

Each byte takes two bus cycles: a read from the source, then a write into video RAM. The same control register also reports progress. While a transfer runs it shows the number of blocks left. It reads all ones once the controller is idle, and it records how many blocks were left when a blanking-mode copy was abandoned. A busy output marks the cycles in which the controller owns the master bus, so the surrounding chip can hold other masters off.

Top module: `vram_dma`

## Requirements
- R1: The source start address is {src_hi, src_lo} (register offsets 0 and 1) with bits 3:0 forced to 0. Each byte read advances it by one, and it wraps from 0xFFFF to 0x0000.
- R2: The destination start address is 0x8000 OR'd with bits 12:4 of {dst_hi, dst_lo} (offsets 2 and 3), with bits 3:0 equal to 0. Each byte advances it by one inside the window, wrapping from 0x9FFF to 0x8000, and every bus write lands in 0x8000–0x9FFF.
- R3: The number of 16-byte blocks moved is bits 6:0 of the control write (offset 4) plus 1.
- R4: Each byte is one cycle with mem_rd high, followed at once by one cycle with mem_wr high. The written data is the mem_rdata the bus returns in that write cycle, which is one cycle after the read. mem_rd and mem_wr are never high together.
- R5: A control write with bit 7 = 0 while idle starts a general transfer on the next cycle. The transfer runs all blocks back to back, 32 cycles per block. While it runs, the control register reads {0, blocks left − 1}. Afterwards it reads 0xFF.
- R6: A control write with bit 7 = 1 while idle arms blanking mode. The control register then reads {0, blocks left − 1}, and no bus cycle occurs until an hblank pulse.
- R7: In blanking mode, each hblank pulse seen while waiting moves exactly 16 bytes. Pulses during a running block are ignored. Bits 6:0 drop by one per block. After the last block the control register reads 0xFF.
- R8: A control write with bit 7 = 0 during a blanking-mode transfer stops it. The control register then reads {1, blocks left − 1}, and later hblank pulses move nothing.
- R9: An hblank pulse in the same cycle as the control write that arms blanking mode, or the same cycle as a cancelling write, starts no block.
- R10: During an active transfer, control writes that do not cancel are ignored. Address register writes do not alter the transfer in progress.
- R11: After reset the control register reads 0xFF, the address registers read 0, offsets 5–7 read 0xFF, and busy, mem_rd and mem_wr are low.
- R12: busy is high exactly in the cycles where mem_rd or mem_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 src_hi, 1 src_lo, 2 dst_hi, 3 dst_lo, 4 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| hblank | input | 1 | One-cycle horizontal-blank event |
| mem_rd | output | 1 | Master bus read strobe |
| mem_wr | output | 1 | Master bus write strobe |
| mem_addr | output | 16 | Master bus address |
| mem_wdata | output | 8 | Master bus write data |
| mem_rdata | input | 8 | Master bus read data, valid the cycle after mem_rd |
| busy | output | 1 | Controller owns the master bus this cycle |

## Verification
Two events can land in one cycle: a control write and an hblank pulse. This happens both at the moment blanking mode is armed and at the moment it is cancelled. The bench raises hblank on the same clock edge as each of those writes. It then watches the master bus for several block lengths and reads back the control register. Passing means no bus write appears and the register shows {0, n−1} after the arming write and {1, n−1} after the cancel.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int AW      = 16;
  localparam int DW      = 8;
  localparam int BLK_LG  = 4;
  localparam int SBLK_W  = AW - BLK_LG;
  localparam int WIN_LG  = 13;
  localparam int DBLK_W  = WIN_LG - BLK_LG;
  localparam int CNT_W   = DW;
  localparam logic [AW-WIN_LG-1:0] WIN_TAG = 3'b100;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} vdma_st_e;

  function automatic logic [SBLK_W-1:0] src_block(input logic [AW-1:0] w);
    return w[AW-1:BLK_LG];
  endfunction

  function automatic logic [DBLK_W-1:0] dst_block(input logic [AW-1:0] w);
    return w[WIN_LG-1:BLK_LG];
  endfunction

  function automatic logic [CNT_W-1:0] block_total(input logic [DW-1:0] c);
    return {1'b0, c[DW-2:0]} + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] left_code(input logic flag, input logic [CNT_W-1:0] left);
    logic [CNT_W-1:0] m1;
    m1 = left - {{(CNT_W-1){1'b0}}, 1'b1};
    return {flag, m1[DW-2:0]};
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] src_word,
  output logic [AW-1:0] dst_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_word <= '0;
      dst_word <= '0;
    end else if (wr) begin
      case (addr)
        3'd0: src_word[AW-1:DW] <= wdata;
        3'd1: src_word[DW-1:0]  <= wdata;
        3'd2: dst_word[AW-1:DW] <= wdata;
        3'd3: dst_word[DW-1:0]  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic [AW-1:0] src_word,
  input  logic [AW-1:0] dst_word,
  input  logic          hblank,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic [DW-1:0] ctl_rdata,
  output logic          start_evt,
  output logic          cancel_evt,
  output logic          fin_evt
);
  vdma_st_e            st;
  logic [BLK_LG-1:0]   idx;
  logic [SBLK_W-1:0]   sblk;
  logic [DBLK_W-1:0]   dblk;
  logic [CNT_W-1:0]    rem;
  logic [CNT_W-1:0]    rem_n;
  logic [DW-1:0]       stat;
  logic                hb_mode;
  logic                active;
  logic                blk_last;

  always_comb begin
    active     = (st != S_IDLE);
    blk_last   = (st == S_WR) && (idx == {BLK_LG{1'b1}});
    rem_n      = rem - {{(CNT_W-1){1'b0}}, blk_last};
    start_evt  = ctl_wr && !active;
    cancel_evt = ctl_wr && active && hb_mode && !ctl_wdata[DW-1];
    fin_evt    = blk_last && (rem == {{(CNT_W-1){1'b0}}, 1'b1}) && !cancel_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      sblk    <= '0;
      dblk    <= '0;
      rem     <= '0;
      hb_mode <= 1'b0;
      stat    <= '1;
    end else if (start_evt) begin
      sblk    <= src_block(src_word);
      dblk    <= dst_block(dst_word);
      rem     <= block_total(ctl_wdata);
      hb_mode <= ctl_wdata[DW-1];
      idx     <= '0;
      st      <= ctl_wdata[DW-1] ? S_WAIT : S_RD;
    end else if (cancel_evt) begin
      st   <= S_IDLE;
      idx  <= '0;
      rem  <= rem_n;
      stat <= (rem_n == '0) ? '1 : left_code(1'b1, rem_n);
    end else begin
      case (st)
        S_WAIT: if (hblank) st <= S_RD;
        S_RD:   st <= S_WR;
        S_WR: begin
          idx <= idx + {{(BLK_LG-1){1'b0}}, 1'b1};
          if (blk_last) begin
            rem  <= rem_n;
            sblk <= sblk + {{(SBLK_W-1){1'b0}}, 1'b1};
            dblk <= dblk + {{(DBLK_W-1){1'b0}}, 1'b1};
            if (fin_evt) begin
              st   <= S_IDLE;
              stat <= '1;
            end else begin
              st <= hb_mode ? S_WAIT : S_RD;
            end
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (st == S_RD);
    mem_wr    = (st == S_WR);
    busy      = mem_rd || mem_wr;
    mem_wdata = mem_rdata;
    if (mem_rd)      mem_addr = {sblk, idx};
    else if (mem_wr) mem_addr = {WIN_TAG, dblk, idx};
    else             mem_addr = '0;
    ctl_rdata = active ? left_code(1'b0, rem) : stat;
  end
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          hblank,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy
);
  logic [AW-1:0] src_word;
  logic [AW-1:0] dst_word;
  logic [DW-1:0] ctl_rdata;
  logic          ctl_wr;
  logic          start_evt;
  logic          cancel_evt;
  logic          fin_evt;

  assign ctl_wr = reg_wr && (reg_addr == 3'd4);

  vdma_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .src_word (src_word),
    .dst_word (dst_word)
  );

  vdma_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (reg_wdata),
    .src_word   (src_word),
    .dst_word   (dst_word),
    .hblank     (hblank),
    .mem_rdata  (mem_rdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .ctl_rdata  (ctl_rdata),
    .start_evt  (start_evt),
    .cancel_evt (cancel_evt),
    .fin_evt    (fin_evt)
  );

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = src_word[AW-1:DW];
      3'd1:    reg_rdata = src_word[DW-1:0];
      3'd2:    reg_rdata = dst_word[AW-1:DW];
      3'd3:    reg_rdata = dst_word[DW-1:0];
      3'd4:    reg_rdata = ctl_rdata;
      default: reg_rdata = '1;
    endcase
  end
endmodule

// File: rtl/vdma_checker.sv
module vdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic        busy,
  input logic        start_evt,
  input logic        cancel_evt,
  input logic        fin_evt
);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  a_r4_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !cancel_evt) |=> mem_wr);

  a_r2_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[15:13] == 3'b100));

  a_r1_blk_align: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $rose(busy)) |-> (mem_addr[3:0] == 4'h0));

  a_r5_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> !busy);

  a_r8_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (!mem_rd && !mem_wr));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);
endmodule

bind vram_dma vdma_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .start_evt  (start_evt),
  .cancel_evt (cancel_evt),
  .fin_evt    (fin_evt)
);

// File: tb/sim_vram_dma.sv
module sim_vram_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic        mem_rd, mem_wr, busy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int wcnt = 0;
  int bus_err = 0;
  logic prev_rd = 1'b0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];

  always #10 clk = ~clk;

  vram_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] + (a[15:8] * 8'd7) + 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= pat(mem_addr);
    if (rst_n) begin
      if (mem_rd && mem_wr) bus_err = bus_err + 1;
      if (mem_wr && !prev_rd) bus_err = bus_err + 1;
      if (busy != (mem_rd || mem_wr)) bus_err = bus_err + 1;
    end
    if (mem_wr) begin
      log_a[wcnt % 256] = mem_addr;
      log_d[wcnt % 256] = mem_wdata;
      wcnt = wcnt + 1;
    end
    prev_rd = mem_rd;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 3'd4;
  endtask

  task automatic pulse();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d);
    wreg(3'd0, s[15:8]); wreg(3'd1, s[7:0]);
    wreg(3'd2, d[15:8]); wreg(3'd3, d[7:0]);
  endtask

  task automatic check_log(input string req, input int base, input int n,
                           input logic [15:0] s0, input logic [15:0] d0);
    int bad = 0;
    logic [15:0] ea, es;
    logic [15:0] fa = 16'h0, fe = 16'h0;
    for (int i = 0; i < n; i++) begin
      es = s0 + 16'(i);
      ea = 16'h8000 | ((d0 + 16'(i)) & 16'h1FFF);
      if (log_a[(base + i) % 256] != ea || log_d[(base + i) % 256] != pat(es)) begin
        if (bad == 0) begin fa = log_a[(base + i) % 256]; fe = ea; end
        bad++;
      end
    end
    chk(req, int'(fa), int'(fe));
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(3'd4, v); chk("R11 ctrl", v, 8'hFF);
    rreg(3'd0, v); chk("R11 src_hi", v, 0);
    rreg(3'd3, v); chk("R11 dst_lo", v, 0);
    rreg(3'd6, v); chk("R11 unused", v, 8'hFF);
    chk("R11 busy", busy, 0);
    chk("R11 rd", mem_rd, 0);
    chk("R11 writes", wcnt, 0);
  endtask

  task automatic t_general();
    int base, n;
    logic [7:0] v;
    setup(16'h1234, 16'hE78F);
    base = wcnt;
    wreg(3'd4, 8'h01);
    n = 0;
    while (busy && n < 500) begin
      if (n == 5)  begin rreg(3'd4, v); chk("R5 mid1", v, 8'h01); end
      if (n == 40) begin rreg(3'd4, v); chk("R5 mid2", v, 8'h00); end
      n++;
      @(negedge clk);
    end
    chk("R5 cycles", n, 64);
    chk("R3 bytes", wcnt - base, 32);
    rreg(3'd4, v); chk("R5 done", v, 8'hFF);
    check_log("R1 R2 general", base, 32, 16'h1230, 16'h8780);
  endtask

  task automatic t_wrap();
    int base;
    setup(16'hFFF5, 16'h9FF3);
    base = wcnt;
    wreg(3'd4, 8'h01);
    wait_idle();
    chk("R3 wrap bytes", wcnt - base, 32);
    check_log("R1 R2 wrap", base, 32, 16'hFFF0, 16'h9FF0);
  endtask

  task automatic t_hblank();
    int base;
    logic [7:0] v;
    setup(16'hC000, 16'h8100);
    base = wcnt;
    wreg(3'd4, 8'h82);
    rreg(3'd4, v); chk("R6 armed", v, 8'h02);
    repeat (40) @(negedge clk);
    chk("R6 no early", wcnt - base, 0);
    pulse(); wait_idle();
    chk("R7 one block", wcnt - base, 16);
    rreg(3'd4, v); chk("R7 left", v, 8'h01);
    pulse();
    repeat (8) @(negedge clk);
    pulse(); wait_idle();
    repeat (40) @(negedge clk);
    chk("R7 mid pulse ignored", wcnt - base, 32);
    wreg(3'd0, 8'h40);
    wreg(3'd4, 8'h85);
    rreg(3'd4, v); chk("R10 ctrl kept", v, 8'h00);
    pulse(); wait_idle();
    chk("R7 total", wcnt - base, 48);
    rreg(3'd4, v); chk("R7 finished", v, 8'hFF);
    check_log("R10 R7 data", base, 48, 16'hC000, 16'h8100);
  endtask

  task automatic t_cancel();
    int base;
    logic [7:0] v;
    setup(16'h2000, 16'h0000);
    base = wcnt;
    wreg(3'd4, 8'h83);
    pulse(); wait_idle();
    wreg(3'd4, 8'h00);
    rreg(3'd4, v); chk("R8 status", v, 8'h82);
    pulse();
    repeat (40) @(negedge clk);
    chk("R8 stopped", wcnt - base, 16);
    chk("R8 busy", busy, 0);
  endtask

  task automatic t_collide();
    int base;
    logic [7:0] v;
    setup(16'h3000, 16'h1000);
    base = wcnt;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h81; hblank = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; hblank = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 arm+pulse", wcnt - base, 0);
    rreg(3'd4, v); chk("R9 armed", v, 8'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00; hblank = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; hblank = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 cancel+pulse", wcnt - base, 0);
    rreg(3'd4, v); chk("R9 cancelled", v, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_general();
    t_wrap();
    t_hblank();
    t_cancel();
    t_collide();
    chk("R4 R12 bus rules", bus_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule